// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a 16-bit asynchronous NOR flash bus. It turns one request on a simple command port into the series of bus cycles that the flash needs. That request can be an array read, an identifier read, a word program, a sector or whole-chip erase, a reset, or one of three unlock-bypass operations. For each cycle it produces the word address, the write data and the chip-enable, write-enable and output-enable strobes. The setup, strobe and hold phases of every cycle each last a number of system clocks given on configuration inputs.

Program and erase operations end with status polling. The sequencer reads the target address again and again until bit 7 shows the true data bit. If bit 5 comes up first, it writes the reset command and reports an error. Identifier reads always end with a reset write, so the device goes back to array mode. Each accepted request gives a one-cycle `ack_o`. Each finished request gives a one-cycle `done_o`, with `err_o` and the read result alongside.

Top module: `nor_cmd_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, `flash_ce_no`, `flash_we_no` and `flash_oe_no` are high, `flash_dq_oe_o` is low, and `ack_o`, `done_o` and `err_o` are low.
- R2: An array read (op 0) performs exactly one read cycle at `addr_i` and no write cycle, and returns the word on `rdata_o` with `done_o`.
- R3: An ID read (op 1) writes AAh@555h, 55h@2AAh and 90h@555h. It then reads word address `addr_i[0]` (0 gives the manufacturer code, 1 the device code), writes F0h@0 and returns the code read. Array reads behave normally afterwards.
- R4: A word program (op 2) writes AAh@555h, 55h@2AAh, A0h@555h and then the data at `addr_i`. It polls `addr_i` until read bit 7 equals data bit 7, then signals done with no error.
- R5: A sector erase (op 3) writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 30h at `addr_i`, whose bits 19..12 select the sector. It polls until bit 7 reads 1. Only that sector is erased.
- R6: A chip erase (op 4) issues the same five leading writes, then 10h@555h, and polls until bit 7 reads 1.
- R7: Op 6 enters unlock-bypass mode with AAh@555h, 55h@2AAh, 20h@555h. Op 7 programs in that mode with only two writes, A0h@0 then the data at `addr_i`, then polls. Op 8 leaves the mode with 90h@0 then 00h@0.
- R8: If a status poll reads bit 5 high while bit 7 still differs from the expected bit, the sequencer writes F0h@0 and ends the request with `done_o` and `err_o` both high.
- R9: In each bus cycle, chip-enable is low for max(`setup_i`,1) clocks before the strobe falls. The strobe is low for max(`pulse_i`,1) clocks. Chip-enable stays low for max(`hold_i`,1) clocks after the strobe rises. Address and data do not change while chip-enable is low. Write-enable and output-enable are never low together.
- R10: Unlock and command writes drive data bits 15..8 as zero. Only the program data cycle carries a full 16-bit word.
- R11: `ack_o` pulses once per accepted request. While a request is in progress, `req_i` is ignored. `done_o` pulses exactly once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when idle |
| op_i | input | 4 | Operation code (0 read, 1 ID, 2 program, 3 sector erase, 4 chip erase, 5 reset, 6 bypass enter, 7 bypass program, 8 bypass exit) |
| addr_i | input | AW | Word address for read, program, ID select or sector |
| wdata_i | input | DW | Program data |
| setup_i | input | TW | Setup clocks, 0 counts as 1 |
| pulse_i | input | TW | Strobe-low clocks, 0 counts as 1 |
| hold_i | input | TW | Hold clocks, 0 counts as 1 |
| ack_o | output | 1 | Request accepted |
| done_o | output | 1 | Request finished |
| err_o | output | 1 | Request finished on a status timeout |
| rdata_o | output | DW | Last word captured by a read or ID operation |
| flash_addr_o | output | AW | Flash word address |
| flash_dq_o | output | DW | Flash write data |
| flash_dq_oe_o | output | 1 | Drive enable for write data |
| flash_dq_i | input | DW | Flash read data |
| flash_ce_no | output | 1 | Chip enable, active low |
| flash_we_no | output | 1 | Write enable, active low |
| flash_oe_no | output | 1 | Output enable, active low |

## Verification
The bench models the flash. In that model, programming ANDs new data into the stored word, and any attempt to raise a 0 to a 1 makes the status report bit 5. A sequencer that polls only bit 7 would therefore hang, and one that skips the recovery write would leave the model busy. The write logs are compared cycle by cycle, so a wrong unlock address, a missing reset after an ID read, non-zero upper command bits or a four-cycle program in bypass mode each shows up as a mismatch. Sector erase is checked against a word in a neighbouring sector, which exposes a sector decode that is too wide. Strobe widths are measured with zero and non-zero settings, which catches a counter that is off by one or treats zero as a wrap.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [3:0] {
    OP_READ      = 4'd0,
    OP_ID        = 4'd1,
    OP_PROG      = 4'd2,
    OP_SERASE    = 4'd3,
    OP_CERASE    = 4'd4,
    OP_RESET     = 4'd5,
    OP_BYP_ENTER = 4'd6,
    OP_BYP_PROG  = 4'd7,
    OP_BYP_EXIT  = 4'd8
  } op_e;

  typedef enum logic [1:0] {K_WR, K_RD, K_POLL, K_END} kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

  localparam logic [7:0] C_UNL1   = 8'hAA;
  localparam logic [7:0] C_UNL2   = 8'h55;
  localparam logic [7:0] C_ID     = 8'h90;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERSET  = 8'h80;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_BYP    = 8'h20;
  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [7:0] C_BYPX2  = 8'h00;
endpackage

// File: rtl/nor_seq_steps.sv
module nor_seq_steps
  import nor_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  op_e             op_i,
  input  logic [2:0]      idx_i,
  input  logic            recov_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output kind_e           kind_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic            pol_o,
  output logic            usr_o
);
  localparam logic [AW-1:0] A_U1 = AW'(12'h555);
  localparam logic [AW-1:0] A_U2 = AW'(12'h2AA);

  function automatic logic [DW-1:0] cmd(input logic [7:0] b);
    return DW'(b);
  endfunction

  logic unl, ers;

  always_comb begin
    kind_o = K_END;
    addr_o = '0;
    data_o = '0;
    pol_o  = 1'b1;
    usr_o  = 1'b0;
    unl = op_i inside {OP_ID, OP_PROG, OP_SERASE, OP_CERASE, OP_BYP_ENTER};
    ers = op_i inside {OP_SERASE, OP_CERASE};
    if (recov_i) begin
      if (idx_i == 3'd0) begin
        kind_o = K_WR;
        data_o = cmd(C_RESET);
      end
    end else if (unl) begin
      case (idx_i)
        3'd0: begin kind_o = K_WR; addr_o = A_U1; data_o = cmd(C_UNL1); end
        3'd1: begin kind_o = K_WR; addr_o = A_U2; data_o = cmd(C_UNL2); end
        3'd2: begin
          kind_o = K_WR;
          addr_o = A_U1;
          case (op_i)
            OP_ID:        data_o = cmd(C_ID);
            OP_PROG:      data_o = cmd(C_PROG);
            OP_BYP_ENTER: data_o = cmd(C_BYP);
            default:      data_o = cmd(C_ERSET);
          endcase
        end
        3'd3: begin
          if (op_i == OP_ID) begin
            kind_o = K_RD;
            addr_o = AW'(addr_i[0]);
          end else if (op_i == OP_PROG) begin
            kind_o = K_WR; addr_o = addr_i; data_o = wdata_i; usr_o = 1'b1;
          end else if (ers) begin
            kind_o = K_WR; addr_o = A_U1; data_o = cmd(C_UNL1);
          end
        end
        3'd4: begin
          if (op_i == OP_ID) begin
            kind_o = K_WR; data_o = cmd(C_RESET);
          end else if (op_i == OP_PROG) begin
            kind_o = K_POLL; addr_o = addr_i; pol_o = wdata_i[7];
          end else if (ers) begin
            kind_o = K_WR; addr_o = A_U2; data_o = cmd(C_UNL2);
          end
        end
        3'd5: begin
          if (ers) begin
            kind_o = K_WR;
            addr_o = (op_i == OP_SERASE) ? addr_i : A_U1;
            data_o = (op_i == OP_SERASE) ? cmd(C_SECT) : cmd(C_CHIP);
          end
        end
        3'd6: begin
          if (ers) begin kind_o = K_POLL; addr_o = addr_i; end
        end
        default: ;
      endcase
    end else begin
      case (op_i)
        OP_READ:  if (idx_i == 3'd0) begin kind_o = K_RD; addr_o = addr_i; end
        OP_RESET: if (idx_i == 3'd0) begin kind_o = K_WR; data_o = cmd(C_RESET); end
        OP_BYP_PROG: begin
          if (idx_i == 3'd0) begin
            kind_o = K_WR; data_o = cmd(C_PROG);
          end else if (idx_i == 3'd1) begin
            kind_o = K_WR; addr_o = addr_i; data_o = wdata_i; usr_o = 1'b1;
          end else if (idx_i == 3'd2) begin
            kind_o = K_POLL; addr_o = addr_i; pol_o = wdata_i[7];
          end
        end
        OP_BYP_EXIT: begin
          if (idx_i == 3'd0) begin
            kind_o = K_WR; data_o = cmd(C_ID);
          end else if (idx_i == 3'd1) begin
            kind_o = K_WR; data_o = cmd(C_BYPX2);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] pulse_i,
  input  logic [TW-1:0] hold_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] f_addr_o,
  output logic [DW-1:0] f_dq_o,
  output logic          f_dq_oe_o,
  input  logic [DW-1:0] f_dq_i,
  output logic          f_ce_no,
  output logic          f_we_no,
  output logic          f_oe_no
);
  phase_e        ph_q;
  logic [TW-1:0] cnt_q;
  logic          rd_q;

  // a zero width still occupies one clock
  function automatic logic [TW-1:0] first(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      rd_q     <= 1'b0;
      f_addr_o <= '0;
      f_dq_o   <= '0;
      rdata_o  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q     <= PH_SETUP;
          cnt_q    <= first(setup_i);
          rd_q     <= rd_i;
          f_addr_o <= addr_i;
          f_dq_o   <= rd_i ? '0 : data_i;
        end
        PH_SETUP: if (cnt_q == '0) begin
          ph_q  <= PH_PULSE;
          cnt_q <= first(pulse_i);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PULSE: if (cnt_q == '0) begin
          ph_q  <= PH_HOLD;
          cnt_q <= first(hold_i);
          if (rd_q) rdata_o <= f_dq_i;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) begin
          ph_q   <= PH_IDLE;
          done_o <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign f_ce_no   = (ph_q == PH_IDLE);
  assign f_we_no   = !((ph_q == PH_PULSE) && !rd_q);
  assign f_oe_no   = !((ph_q == PH_PULSE) && rd_q);
  assign f_dq_oe_o = (ph_q != PH_IDLE) && !rd_q;

  a_r9_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!f_we_no && !f_oe_no));
  a_r9_ce_leads_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(f_we_no) |-> $past(!f_ce_no));
  a_r9_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!f_ce_no && $past(!f_ce_no)) |-> $stable(f_addr_o));
  a_r9_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_dq_oe_o && $past(f_dq_oe_o)) |-> $stable(f_dq_o));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] pulse_i,
  input  logic [TW-1:0] hold_i,
  output logic          ack_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [DW-1:0] flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [DW-1:0] flash_dq_i,
  output logic          flash_ce_no,
  output logic          flash_we_no,
  output logic          flash_oe_no
);
  seq_state_e    st_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [2:0]    idx_q;
  logic          recov_q, err_q;

  kind_e         st_kind;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          st_pol, st_usr;
  logic          cyc_start, cyc_done;
  logic [DW-1:0] cyc_rdata;

  nor_seq_steps #(.AW(AW), .DW(DW)) u_steps (
    .op_i   (op_q),
    .idx_i  (idx_q),
    .recov_i(recov_q),
    .addr_i (addr_q),
    .wdata_i(wdata_q),
    .kind_o (st_kind),
    .addr_o (st_addr),
    .data_o (st_data),
    .pol_o  (st_pol),
    .usr_o  (st_usr)
  );

  assign cyc_start = (st_q == S_ISSUE) && (st_kind != K_END);

  nor_bus_cycle #(.AW(AW), .DW(DW), .TW(TW)) u_cycle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cyc_start),
    .rd_i     (st_kind != K_WR),
    .addr_i   (st_addr),
    .data_i   (st_data),
    .setup_i  (setup_i),
    .pulse_i  (pulse_i),
    .hold_i   (hold_i),
    .done_o   (cyc_done),
    .rdata_o  (cyc_rdata),
    .f_addr_o (flash_addr_o),
    .f_dq_o   (flash_dq_o),
    .f_dq_oe_o(flash_dq_oe_o),
    .f_dq_i   (flash_dq_i),
    .f_ce_no  (flash_ce_no),
    .f_we_no  (flash_we_no),
    .f_oe_no  (flash_oe_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
      recov_q <= 1'b0;
      err_q   <= 1'b0;
      ack_o   <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o  <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st_q)
        S_IDLE: if (req_i) begin
          op_q    <= op_e'(op_i);
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          idx_q   <= '0;
          recov_q <= 1'b0;
          err_q   <= 1'b0;
          ack_o   <= 1'b1;
          st_q    <= S_ISSUE;
        end
        S_ISSUE: begin
          if (st_kind == K_END) begin
            done_o <= 1'b1;
            err_o  <= err_q;
            st_q   <= S_IDLE;
          end else st_q <= S_WAIT;
        end
        S_WAIT: if (cyc_done) begin
          st_q <= S_ISSUE;
          case (st_kind)
            K_RD: begin
              rdata_o <= cyc_rdata;
              idx_q   <= idx_q + 1'b1;
            end
            K_POLL: begin
              if (cyc_rdata[7] == st_pol) idx_q <= idx_q + 1'b1;
              else if (cyc_rdata[5]) begin
                recov_q <= 1'b1;
                err_q   <= 1'b1;
                idx_q   <= '0;
              end
            end
            default: idx_q <= idx_q + 1'b1;
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r10_cmd_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT && !st_usr && !flash_we_no) |-> (flash_dq_o[DW-1:8] == '0));
  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r11_ack_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && done_o));
  a_r11_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;
  import nor_seq_pkg::*;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam logic [15:0] MFR_CODE = 16'h0001;
  localparam logic [15:0] DEV_CODE = 16'h1A5C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [3:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [TW-1:0] setup = 4'd1, pulse = 4'd2, hold = 4'd1;
  logic ack, done, err, dq_oe, ce_n, we_n, oe_n;
  logic [DW-1:0] rdata, dq_o;
  logic [DW-1:0] dq_i = '0;
  logic [AW-1:0] fa;

  always #4 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .DW(DW), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .setup_i(setup), .pulse_i(pulse), .hold_i(hold),
    .ack_o(ack), .done_o(done), .err_o(err), .rdata_o(rdata),
    .flash_addr_o(fa), .flash_dq_o(dq_o), .flash_dq_oe_o(dq_oe),
    .flash_dq_i(dq_i), .flash_ce_no(ce_n), .flash_we_no(we_n), .flash_oe_no(oe_n)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [15:0] mem [logic [AW-1:0]];
  logic [AW+DW-1:0] wlog[$];
  int mode = 0;          // 0 array, 1 id, 2 bypass
  int seq = 0, left = 0;
  bit armed = 0, want_pd = 0, byp_x = 0, busy = 0, pbit = 0, fail = 0;

  function automatic logic [15:0] arr(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 16'hFFFF;
  endfunction

  task automatic start_erase();
    busy = 1; left = 4; pbit = 1; fail = 0;
  endtask

  always @(posedge we_n) if (rst_n && !ce_n) begin
    logic [7:0] c8;
    c8 = dq_o[7:0];
    wlog.push_back({fa, dq_o});
    if (busy) begin
      if (c8 == 8'hF0) begin busy = 0; fail = 0; mode = 0; end
    end else if (want_pd) begin
      logic [15:0] nw;
      nw = arr(fa) & dq_o;
      mem[fa] = nw;
      want_pd = 0; busy = 1; left = 3; pbit = dq_o[7]; fail = (nw != dq_o);
    end else if (mode == 2) begin
      if (c8 == 8'hA0) want_pd = 1;
      else if (c8 == 8'h90) byp_x = 1;
      else if (byp_x && c8 == 8'h00) begin mode = 0; byp_x = 0; end
      else if (c8 == 8'hF0) mode = 0;
    end else if (c8 == 8'hF0) begin
      mode = 0; seq = 0; armed = 0;
    end else begin
      case (seq)
        0: if (fa == 20'h555 && c8 == 8'hAA) seq = 1;
        1: seq = (fa == 20'h2AA && c8 == 8'h55) ? 2 : 0;
        default: begin
          seq = 0;
          if (armed) begin
            armed = 0;
            if (c8 == 8'h30) begin
              logic [AW-1:0] ks[$];
              foreach (mem[k]) if (k[AW-1:12] == fa[AW-1:12]) ks.push_back(k);
              foreach (ks[i]) mem.delete(ks[i]);
              start_erase();
            end else if (c8 == 8'h10 && fa == 20'h555) begin
              mem.delete();
              start_erase();
            end
          end else if (fa == 20'h555) begin
            case (c8)
              8'h90: mode = 1;
              8'hA0: want_pd = 1;
              8'h80: armed = 1;
              8'h20: mode = 2;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always @(negedge oe_n) if (rst_n) begin
    if (busy) dq_i = {8'h00, ~pbit, 1'b0, fail, 5'h00};
    else if (mode == 1) dq_i = fa[0] ? DEV_CODE : MFR_CODE;
    else dq_i = arr(fa);
  end

  always @(posedge oe_n) if (rst_n && busy && !fail) begin
    left--;
    if (left == 0) busy = 0;
  end

  // ---------------- strobe width monitor ----------------
  int sc = 0, pc = 0, hc = 0, ph = 0, l_setup = 0, l_pulse = 0, l_hold = 0;
  logic pce = 1'b1;
  int ack_cnt = 0;
  always @(negedge clk) if (rst_n) begin
    if (ack) ack_cnt++;
    if (!ce_n) begin
      if (!we_n) begin pc++; ph = 1; end
      else if (ph == 0) sc++;
      else hc++;
    end else if (!pce) begin
      l_setup = sc; l_pulse = pc; l_hold = hc;
      sc = 0; pc = 0; hc = 0; ph = 0;
    end
    pce = ce_n;
  end

  // ---------------- scoreboard ----------------
  typedef struct {string tag; bit chk_rd; logic [15:0] rd; bit er;} exp_t;
  exp_t sb[$];

  always @(negedge clk) if (rst_n && done) begin
    if (sb.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
    else begin
      exp_t e;
      e = sb.pop_front();
      chk(err == e.er, e.tag, "err_o", err, e.er);
      if (e.chk_rd) chk(rdata == e.rd, e.tag, "rdata_o", rdata, e.rd);
    end
  end

  task automatic run(input op_e o, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input string tag, input bit c, input logic [15:0] rd, input bit er);
    exp_t e;
    e.tag = tag; e.chk_rd = c; e.rd = rd; e.er = er;
    wlog.delete();
    sb.push_back(e);
    @(negedge clk);
    req = 1; op = 4'(o); addr = a; wdata = d;
    do @(negedge clk); while (!ack);
    req = 0;
    do @(negedge clk); while (sb.size() != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_at(input int i, input logic [AW-1:0] a, input logic [15:0] d,
                       input string rq);
    logic [AW+DW-1:0] act;
    act = (wlog.size() > i) ? wlog[i] : '1;
    chk(act == {a, d}, rq, $sformatf("write %0d", i), act, {a, d});
  endtask

  task automatic nwr(input int n, input string rq);
    chk(wlog.size() == n, rq, "write count", wlog.size(), n);
  endtask

  initial begin
    #1600000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({ce_n, we_n, oe_n, dq_oe, ack, done, err} == 7'b1110000, "R1", "reset outputs",
        {ce_n, we_n, oe_n, dq_oe, ack, done, err}, 7'b1110000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({ce_n, we_n, oe_n, dq_oe} == 4'b1110, "R1", "idle after reset",
        {ce_n, we_n, oe_n, dq_oe}, 4'b1110);

    run(OP_READ, 20'h00042, '0, "R2", 1, 16'hFFFF, 0);
    nwr(0, "R2");

    run(OP_ID, 20'h0, '0, "R3", 1, MFR_CODE, 0);
    nwr(4, "R3");
    wr_at(0, 20'h555, 16'h00AA, "R3");
    wr_at(1, 20'h2AA, 16'h0055, "R10");
    wr_at(2, 20'h555, 16'h0090, "R3");
    wr_at(3, 20'h0, 16'h00F0, "R3");
    run(OP_ID, 20'h1, '0, "R3", 1, DEV_CODE, 0);
    run(OP_READ, 20'h1, '0, "R3", 1, 16'hFFFF, 0);

    run(OP_PROG, 20'h01234, 16'h5AC3, "R4", 0, '0, 0);
    nwr(4, "R4");
    wr_at(2, 20'h555, 16'h00A0, "R4");
    wr_at(3, 20'h01234, 16'h5AC3, "R4");
    run(OP_READ, 20'h01234, '0, "R4", 1, 16'h5AC3, 0);
    run(OP_PROG, 20'h01234, 16'h50C1, "R4", 0, '0, 0);
    run(OP_READ, 20'h01234, '0, "R4", 1, 16'h50C1, 0);

    run(OP_PROG, 20'h01234, 16'hFFFF, "R8", 0, '0, 1);
    wr_at(4, 20'h0, 16'h00F0, "R8");
    chk(busy == 0, "R8", "flash left busy", busy, 0);
    run(OP_READ, 20'h01234, '0, "R8", 1, 16'h50C1, 0);

    run(OP_PROG, 20'h02005, 16'h1234, "R4", 0, '0, 0);
    run(OP_SERASE, 20'h01000, '0, "R5", 0, '0, 0);
    nwr(6, "R5");
    wr_at(2, 20'h555, 16'h0080, "R5");
    wr_at(5, 20'h01000, 16'h0030, "R5");
    run(OP_READ, 20'h01234, '0, "R5", 1, 16'hFFFF, 0);
    run(OP_READ, 20'h02005, '0, "R5", 1, 16'h1234, 0);

    run(OP_CERASE, 20'h0, '0, "R6", 0, '0, 0);
    nwr(6, "R6");
    wr_at(5, 20'h555, 16'h0010, "R6");
    run(OP_READ, 20'h02005, '0, "R6", 1, 16'hFFFF, 0);

    run(OP_BYP_ENTER, 20'h0, '0, "R7", 0, '0, 0);
    nwr(3, "R7");
    wr_at(2, 20'h555, 16'h0020, "R7");
    run(OP_BYP_PROG, 20'h00777, 16'hA5F0, "R7", 0, '0, 0);
    nwr(2, "R7");
    wr_at(0, 20'h0, 16'h00A0, "R7");
    wr_at(1, 20'h00777, 16'hA5F0, "R7");
    run(OP_BYP_EXIT, 20'h0, '0, "R7", 0, '0, 0);
    wr_at(0, 20'h0, 16'h0090, "R7");
    wr_at(1, 20'h0, 16'h0000, "R7");
    chk(mode == 0, "R7", "mode after exit", mode, 0);
    run(OP_READ, 20'h00777, '0, "R7", 1, 16'hA5F0, 0);

    run(OP_RESET, 20'h0, '0, "R9", 0, '0, 0);
    chk(l_setup == 1 && l_pulse == 2 && l_hold == 1, "R9", "widths 1/2/1",
        {l_setup[7:0], l_pulse[7:0], l_hold[7:0]}, 24'h010201);
    setup = 4'd3; pulse = 4'd0; hold = 4'd2;
    run(OP_RESET, 20'h0, '0, "R9", 0, '0, 0);
    chk(l_setup == 3 && l_pulse == 1 && l_hold == 2, "R9", "widths 3/0/2",
        {l_setup[7:0], l_pulse[7:0], l_hold[7:0]}, 24'h030102);
    setup = 4'd0; pulse = 4'd5; hold = 4'd0;
    run(OP_RESET, 20'h0, '0, "R9", 0, '0, 0);
    chk(l_setup == 1 && l_pulse == 5 && l_hold == 1, "R9", "widths 0/5/0",
        {l_setup[7:0], l_pulse[7:0], l_hold[7:0]}, 24'h010501);
    setup = 4'd1; pulse = 4'd2; hold = 4'd1;
    run(OP_READ, 20'h00777, '0, "R9", 1, 16'hA5F0, 0);

    begin
      exp_t e;
      int a0;
      e.tag = "R11"; e.chk_rd = 0; e.rd = '0; e.er = 0;
      sb.push_back(e);
      a0 = ack_cnt;
      @(negedge clk);
      req = 1; op = 4'(OP_RESET); addr = '0;
      do @(negedge clk); while (!done);
      req = 0;
      repeat (3) @(negedge clk);
      chk(ack_cnt - a0 == 1, "R11", "acks while req held", ack_cnt - a0, 1);
      chk(sb.size() == 0, "R11", "done count", sb.size(), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule